// File: doc/BRIEF.md
# SEC-DED Memory Word Protector with Byte-Masked Write-Back

This block guards a 32-bit memory word with an 8-bit check code. It sits between a system data bus and a memory data bus. On a read, the word and its stored check code are captured from memory. The block then forms a syndrome and reports whether any error occurred. It also reports whether the error is beyond repair. When only one bit of the 40-bit code word is wrong, it fixes that bit. The repaired word can be captured into an output pipeline register for the system side.

On a write, system data is captured in its own register. Each of four byte enables picks, for one byte, either the new system byte or the repaired old memory byte. The merged word goes out on the memory side together with a fresh check code computed from it. A full write uses all four enables. With no enables set, the repaired read word is written back as it is, which serves as a scrub.

The system side carries one parity bit per byte. The block checks incoming parity against the latched system data. It generates outgoing parity for the pipelined read word. A select input chooses even or odd parity.

Top module: `edc_unit`

## Requirements
- R1: The check code of a word sets check bit j to the XOR of every data bit i whose column has bit j set. The column of data bit i is the i-th smallest 8-bit value with exactly three ones, counting from i = 0. The column of check bit j has only bit j set.
- R2: The syndrome is the check code of the latched memory data XOR the latched check bits. When it is zero, err_o and merr_o are 0 and the data passes unchanged.
- R3: A single wrong data bit gives a syndrome equal to that bit's column. It sets err_o, clears merr_o, and the bit is inverted in the repaired word.
- R4: A single wrong check bit sets err_o and clears merr_o. The 32 data bits pass unchanged.
- R5: Any two wrong bits among the 40 set both err_o and merr_o. The data passes uncorrected.
- R6: Byte b of mem_data_o (bits 8b+7..8b) is the latched system byte when byte_en[b] is 1. Otherwise it is the repaired memory byte. mem_cb_o is the R1 code of mem_data_o.
- R7: The memory data and check bits are captured on a clock edge with mem_le high. They hold while mem_le is low.
- R8: The system data and parity bits are captured on a clock edge with sys_le high. They hold while sys_le is low.
- R9: sys_data_o takes the repaired memory word on the clock edge after pipe_le is seen high. It holds while pipe_le is low.
- R10: sys_par_o[b] equals the XOR of byte b of sys_data_o XOR par_odd.
- R11: par_err_o is 1 exactly when some latched parity bit differs from the R10 rule applied to the same byte of the latched system data.
- R12: After reset, all registers are zero. So sys_data_o is 0, err_o and merr_o are 0, and mem_cb_o is 0 with no byte enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_le | input | 1 | Capture enable for memory data and check bits |
| mem_data_i | input | 32 | Data word read from memory |
| mem_cb_i | input | 8 | Check bits read from memory |
| sys_le | input | 1 | Capture enable for system data and parity |
| sys_data_i | input | 32 | Data word from the system bus |
| sys_par_i | input | 4 | Per-byte parity from the system bus |
| byte_en | input | 4 | Selects system bytes over repaired memory bytes |
| pipe_le | input | 1 | Load enable of the output pipeline register |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| sys_data_o | output | 32 | Pipelined repaired word for the system bus |
| sys_par_o | output | 4 | Parity of sys_data_o |
| mem_data_o | output | 32 | Merged word for write-back |
| mem_cb_o | output | 8 | Check bits of mem_data_o |
| syndrome_o | output | 8 | Syndrome of the latched memory word |
| err_o | output | 1 | Any error found |
| merr_o | output | 1 | Uncorrectable error found |
| par_err_o | output | 1 | System-side parity mismatch |

## Verification
A bad column table or a bad repair path shows up as soon as a word is captured. In the same cycle, the syndrome, the flags or the merged write-back word come out wrong. Every one of the 40 single-bit faults is tried, so even a single miswired column is found. A stuck or mis-enabled capture register shows up one clock after its enable. The pipelined word or the parity outputs then keep a stale value, or change when they should hold.

// File: rtl/edc_pkg.sv
package edc_pkg;

   // population count used by the column-table construction
   function automatic int unsigned edc_ones(input logic [31:0] v);
      int unsigned n;
      n = 0;
      for (int k = 0; k < 32; k++) n += int'(v[k]);
      return n;
   endfunction

   // number of distinct weight-three codes of a given width
   function automatic int unsigned edc_w3_count(input int unsigned cbw);
      return (cbw * (cbw - 1) * (cbw - 2)) / 6;
   endfunction

   // column of data bit idx: idx-th smallest weight-three value
   function automatic logic [31:0] edc_col(input int unsigned idx, input int unsigned cbw);
      int unsigned cnt;
      logic [31:0] res;
      cnt = 0;
      res = '0;
      for (int unsigned v = 0; v < (32'd1 << cbw); v++) begin
         if (edc_ones(v) == 3) begin
            if (cnt == idx) res = v;
            cnt++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/edc_chkgen.sv
module edc_chkgen #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CB_W   = 8
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CB_W-1:0]   cb_o
);
   logic [DATA_W-1:0][CB_W-1:0] term;

   for (genvar i = 0; i < DATA_W; i++) begin : g_col
      localparam logic [CB_W-1:0] COL = CB_W'(edc_pkg::edc_col(i, CB_W));
      assign term[i] = data_i[i] ? COL : '0;
   end

   always_comb begin
      cb_o = '0;
      for (int i = 0; i < DATA_W; i++) cb_o ^= term[i];
   end
endmodule

// File: rtl/edc_syndec.sv
module edc_syndec #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CB_W   = 8
) (
   input  logic [CB_W-1:0]   syn_i,
   output logic [DATA_W-1:0] flip_o,
   output logic              err_o,
   output logic              merr_o
);
   logic cb_hit;

   for (genvar i = 0; i < DATA_W; i++) begin : g_match
      localparam logic [CB_W-1:0] COL = CB_W'(edc_pkg::edc_col(i, CB_W));
      assign flip_o[i] = (syn_i == COL);
   end

   // single check-bit fault: syndrome with exactly one bit set
   assign cb_hit = (syn_i != '0) && ((syn_i & (syn_i - CB_W'(1))) == '0);
   assign err_o  = |syn_i;
   assign merr_o = err_o & ~(|flip_o) & ~cb_hit;
endmodule

// File: rtl/edc_bytepar.sv
module edc_bytepar #(
   parameter int unsigned NBYTES = 4,
   parameter int unsigned BYTE_W = 8
) (
   input  logic [NBYTES*BYTE_W-1:0] data_i,
   input  logic                     odd_i,
   output logic [NBYTES-1:0]        par_o
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign par_o[b] = (^data_i[b*BYTE_W +: BYTE_W]) ^ odd_i;
   end
endmodule

// File: rtl/edc_unit.sv
module edc_unit #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CB_W   = 8,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NBYTES = DATA_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mem_le,
   input  logic [DATA_W-1:0] mem_data_i,
   input  logic [CB_W-1:0]   mem_cb_i,
   input  logic              sys_le,
   input  logic [DATA_W-1:0] sys_data_i,
   input  logic [NBYTES-1:0] sys_par_i,
   input  logic [NBYTES-1:0] byte_en,
   input  logic              pipe_le,
   input  logic              par_odd,
   output logic [DATA_W-1:0] sys_data_o,
   output logic [NBYTES-1:0] sys_par_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic [CB_W-1:0]   mem_cb_o,
   output logic [CB_W-1:0]   syndrome_o,
   output logic              err_o,
   output logic              merr_o,
   output logic              par_err_o
);
   if (DATA_W % BYTE_W != 0) begin : g_bad_bytes
      $error("edc_unit: DATA_W must be a multiple of BYTE_W");
   end
   if (CB_W < 3 || CB_W > 16 || edc_pkg::edc_w3_count(CB_W) < DATA_W) begin : g_bad_code
      $error("edc_unit: CB_W too small or too large for DATA_W");
   end

   logic [DATA_W-1:0] mem_q, sys_q, pipe_q, fixed_w, merged_w, flip_w;
   logic [CB_W-1:0]   cb_q, rd_cb_w, syn_w;
   logic [NBYTES-1:0] spar_q, exp_par_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
         cb_q  <= '0;
      end else if (mem_le) begin
         mem_q <= mem_data_i;
         cb_q  <= mem_cb_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_q  <= '0;
         spar_q <= '0;
      end else if (sys_le) begin
         sys_q  <= sys_data_i;
         spar_q <= sys_par_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pipe_q <= '0;
      else if (pipe_le) pipe_q <= fixed_w;
   end

   edc_chkgen #(.DATA_W(DATA_W), .CB_W(CB_W)) u_gen_rd (
      .data_i(mem_q), .cb_o(rd_cb_w));

   assign syn_w = rd_cb_w ^ cb_q;

   edc_syndec #(.DATA_W(DATA_W), .CB_W(CB_W)) u_dec (
      .syn_i(syn_w), .flip_o(flip_w), .err_o(err_o), .merr_o(merr_o));

   assign fixed_w = mem_q ^ flip_w;

   for (genvar b = 0; b < NBYTES; b++) begin : g_merge
      assign merged_w[b*BYTE_W +: BYTE_W] = byte_en[b] ? sys_q[b*BYTE_W +: BYTE_W]
                                                       : fixed_w[b*BYTE_W +: BYTE_W];
   end

   edc_chkgen #(.DATA_W(DATA_W), .CB_W(CB_W)) u_gen_wr (
      .data_i(merged_w), .cb_o(mem_cb_o));

   edc_bytepar #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_par_out (
      .data_i(pipe_q), .odd_i(par_odd), .par_o(sys_par_o));

   edc_bytepar #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_par_in (
      .data_i(sys_q), .odd_i(par_odd), .par_o(exp_par_w));

   assign par_err_o  = |(exp_par_w ^ spar_q);
   assign sys_data_o = pipe_q;
   assign mem_data_o = merged_w;
   assign syndrome_o = syn_w;
endmodule

// File: rtl/edc_unit_chk.sv
module edc_unit_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CB_W   = 8,
   parameter int unsigned NBYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_le,
   input logic              sys_le,
   input logic              pipe_le,
   input logic [NBYTES-1:0] byte_en,
   input logic [DATA_W-1:0] sys_data_i,
   input logic [DATA_W-1:0] mem_data_o,
   input logic [DATA_W-1:0] sys_data_o,
   input logic [CB_W-1:0]   syndrome_o,
   input logic              err_o,
   input logic              merr_o
);
   // R5: an uncorrectable report is always also an error report
   a_r5_merr_has_err: assert property (@(posedge clk) disable iff (!rst_n)
      merr_o |-> err_o);

   a_r7_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_le |=> ($stable(syndrome_o) && $stable(err_o) && $stable(merr_o)));

   a_r9_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pipe_le |=> $stable(sys_data_o));

   a_r9_pipe_load: assert property (@(posedge clk) disable iff (!rst_n)
      (pipe_le && byte_en == '0) |=> (sys_data_o == $past(mem_data_o)));

   a_r6_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      sys_le |=> ((byte_en != '1) || (mem_data_o == $past(sys_data_i))));
endmodule

bind edc_unit edc_unit_chk #(.DATA_W(DATA_W), .CB_W(CB_W), .NBYTES(NBYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_le(mem_le), .sys_le(sys_le), .pipe_le(pipe_le),
   .byte_en(byte_en), .sys_data_i(sys_data_i), .mem_data_o(mem_data_o),
   .sys_data_o(sys_data_o), .syndrome_o(syndrome_o), .err_o(err_o), .merr_o(merr_o));

// File: tb/edc_unit_bench.sv
module edc_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_le = 1'b0, sys_le = 1'b0, pipe_le = 1'b0, par_odd = 1'b0;
   logic [31:0] mem_data_i = '0, sys_data_i = '0;
   logic [7:0]  mem_cb_i = '0;
   logic [3:0]  sys_par_i = '0, byte_en = '0;
   logic [31:0] sys_data_o, mem_data_o;
   logic [3:0]  sys_par_o;
   logic [7:0]  mem_cb_o, syndrome_o;
   logic        err_o, merr_o, par_err_o;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   edc_unit u_edc_unit (
      .clk(clk), .rst_n(rst_n), .mem_le(mem_le), .mem_data_i(mem_data_i),
      .mem_cb_i(mem_cb_i), .sys_le(sys_le), .sys_data_i(sys_data_i),
      .sys_par_i(sys_par_i), .byte_en(byte_en), .pipe_le(pipe_le),
      .par_odd(par_odd), .sys_data_o(sys_data_o), .sys_par_o(sys_par_o),
      .mem_data_o(mem_data_o), .mem_cb_o(mem_cb_o), .syndrome_o(syndrome_o),
      .err_o(err_o), .merr_o(merr_o), .par_err_o(par_err_o));

   // column of data bit i per R1
   function automatic logic [7:0] bcol(input int i);
      int cnt;
      logic [7:0] r;
      cnt = 0;
      r = '0;
      for (int v = 0; v < 256; v++) begin
         if ($countones(8'(v)) == 3) begin
            if (cnt == i) r = 8'(v);
            cnt++;
         end
      end
      return r;
   endfunction

   function automatic logic [7:0] bgen(input logic [31:0] d);
      logic [7:0] c;
      c = '0;
      for (int i = 0; i < 32; i++) if (d[i]) c ^= bcol(i);
      return c;
   endfunction

   function automatic logic [3:0] bpar(input logic [31:0] d, input logic odd);
      logic [3:0] p;
      for (int b = 0; b < 4; b++) p[b] = (^d[b*8 +: 8]) ^ odd;
      return p;
   endfunction

   function automatic logic [31:0] bmerge(input logic [31:0] s, input logic [31:0] m,
                                          input logic [3:0] be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? s[b*8 +: 8] : m[b*8 +: 8];
      return r;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_mem(input logic [31:0] d, input logic [7:0] c);
      @(negedge clk);
      mem_data_i = d;
      mem_cb_i   = c;
      mem_le     = 1'b1;
      @(negedge clk);
      mem_le = 1'b0;
   endtask

   task automatic load_sys(input logic [31:0] d, input logic [3:0] p);
      @(negedge clk);
      sys_data_i = d;
      sys_par_i  = p;
      sys_le     = 1'b1;
      @(negedge clk);
      sys_le = 1'b0;
   endtask

   task automatic pulse_pipe;
      pipe_le = 1'b1;
      @(negedge clk);
      pipe_le = 1'b0;
   endtask

   // data, first error position, second error position (63 = none)
   localparam logic [43:0] VEC [8] = '{
      {32'h0000_0000, 6'd63, 6'd63},
      {32'h0F0F_F0F0, 6'd63, 6'd63},
      {32'hDEAD_BEEF, 6'd5,  6'd63},
      {32'h8000_0001, 6'd35, 6'd63},
      {32'hFFFF_FFFF, 6'd0,  6'd1},
      {32'hA5A5_5A5A, 6'd31, 6'd32},
      {32'h1234_5678, 6'd39, 6'd38},
      {32'hCAFE_F00D, 6'd10, 6'd20}
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 sys_data_o", 64'(sys_data_o), 64'h0);
      chk("R12 err/merr", {62'h0, err_o, merr_o}, 64'h0);
      chk("R12 mem_cb_o", 64'(mem_cb_o), 64'h0);
      chk("R12 sys_par_o", 64'(sys_par_o), 64'h0);

      // vector table: R2 clean, R3/R4 single, R5 double
      for (int t = 0; t < 8; t++) begin
         logic [31:0] d;
         logic [39:0] cw;
         int pa, pb, ne;
         d  = VEC[t][43:12];
         pa = int'(VEC[t][11:6]);
         pb = int'(VEC[t][5:0]);
         cw = {bgen(d), d};
         ne = 0;
         if (pa != 63) begin cw ^= 40'd1 << pa; ne++; end
         if (pb != 63) begin cw ^= 40'd1 << pb; ne++; end
         byte_en = 4'h0;
         load_mem(cw[31:0], cw[39:32]);
         chk("R2_R3_R4_R5 data", 64'(mem_data_o), 64'(ne == 2 ? cw[31:0] : d));
         chk("R2_R3_R4_R5 err", 64'(err_o), 64'(ne != 0));
         chk("R5 merr", 64'(merr_o), 64'(ne == 2));
         pulse_pipe();
         chk("R9 pipe load", 64'(sys_data_o), 64'(ne == 2 ? cw[31:0] : d));
      end

      // every single-bit error over all 40 code bits
      for (int k = 0; k < 40; k++) begin
         logic [31:0] d;
         logic [39:0] cw;
         d  = 32'h3C5A_96E1 ^ (32'h0101_0101 * 32'(k));
         cw = {bgen(d), d} ^ (40'd1 << k);
         load_mem(cw[31:0], cw[39:32]);
         if (k < 32) chk("R3 syndrome", 64'(syndrome_o), 64'(bcol(k)));
         else        chk("R4 syndrome", 64'(syndrome_o), 64'(8'd1 << (k - 32)));
         chk("R3_R4 corrected", 64'(mem_data_o), 64'(d));
         chk("R3_R4 flags", {62'h0, err_o, merr_o}, 64'h2);
      end

      // R6 byte-masked merge with corrected old data
      begin
         logic [31:0] od, nd;
         logic [39:0] cw;
         od = 32'h1122_3344;
         nd = 32'hAABB_CCDD;
         cw = {bgen(od), od} ^ (40'd1 << 7);
         load_mem(cw[31:0], cw[39:32]);
         load_sys(nd, bpar(nd, 1'b0));
         for (int m = 0; m < 4; m++) begin
            logic [3:0] be;
            be = (m == 0) ? 4'b0101 : (m == 1) ? 4'b1010 : (m == 2) ? 4'b1111 : 4'b0000;
            byte_en = be;
            @(negedge clk);
            chk("R6 merged", 64'(mem_data_o), 64'(bmerge(nd, od, be)));
            chk("R6 cb", 64'(mem_cb_o), 64'(bgen(bmerge(nd, od, be))));
         end
         // R8 hold: new system data without enable has no effect
         byte_en = 4'hF;
         sys_data_i = 32'h0000_0000;
         @(negedge clk);
         @(negedge clk);
         chk("R8 sys hold", 64'(mem_data_o), 64'(nd));
         // R7 hold: new memory data without enable has no effect
         byte_en = 4'h0;
         mem_data_i = 32'hFFFF_0000;
         mem_cb_i = 8'h00;
         @(negedge clk);
         @(negedge clk);
         chk("R7 mem hold", 64'(mem_data_o), 64'(od));
         chk("R7 syndrome hold", 64'(syndrome_o), 64'(bcol(7)));
      end

      // R9 hold and R10 output parity
      begin
         logic [31:0] w;
         w = 32'h0137_F8A2;
         load_mem(w, bgen(w));
         pulse_pipe();
         load_mem(32'h5555_AAAA, bgen(32'h5555_AAAA));
         @(negedge clk);
         chk("R9 pipe hold", 64'(sys_data_o), 64'(w));
         par_odd = 1'b0;
         @(negedge clk);
         chk("R10 even", 64'(sys_par_o), 64'(bpar(w, 1'b0)));
         par_odd = 1'b1;
         @(negedge clk);
         chk("R10 odd", 64'(sys_par_o), 64'(bpar(w, 1'b1)));
      end

      // R11 input parity check
      begin
         logic [31:0] s;
         s = 32'h8F01_7E33;
         par_odd = 1'b0;
         load_sys(s, bpar(s, 1'b0));
         chk("R11 even ok", 64'(par_err_o), 64'h0);
         load_sys(s, bpar(s, 1'b0) ^ 4'b0100);
         chk("R11 even bad", 64'(par_err_o), 64'h1);
         par_odd = 1'b1;
         load_sys(s, bpar(s, 1'b1));
         chk("R11 odd ok", 64'(par_err_o), 64'h0);
         load_sys(s, bpar(s, 1'b0));
         chk("R11 odd vs even", 64'(par_err_o), 64'h1);
      end

      // R12 reset mid-run clears the registers
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      byte_en = 4'h0;
      @(negedge clk);
      chk("R12 re-reset sys_data_o", 64'(sys_data_o), 64'h0);
      chk("R12 re-reset mem_cb_o", 64'(mem_cb_o), 64'h0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule